// File: doc/BRIEF.md
# Indirect PHY configuration mailbox

This block sits on the host side of a PHY configuration path. Software does not address the PHY registers directly. It writes one 32-bit mailbox word that holds a register address, a byte of write data and two strobe bits, and it reads the same word back to follow an acknowledge flag and collect read data. The block turns each strobe into a four-phase request/acknowledge exchange with a model PHY register file. That file holds 64 entries of 8 bits.

A typical driver brings the PHY up by walking a list of address/data pairs, one access at a time. For each pair it waits for ACK low, loads address and data with the strobes clear, and sets WR. It then waits for ACK high, clears WR and waits for ACK low again. Every wait is bounded, and the list is abandoned on the first wait that expires. A read works the same way with RD, and the data is taken from the word once ACK shows high.

The host side is a four-state machine. H_IDLE goes to H_REQ when a strobe is set and no acknowledge is pending; at that point it latches the operation, address and data. H_REQ goes to H_HOLD when the PHY acknowledges. H_HOLD goes to H_DRAIN when software clears the strobe of the active operation. H_DRAIN goes back to H_IDLE once the PHY drops its acknowledge. The PHY side has three states. P_IDLE goes to P_WAIT on a request. P_WAIT goes to P_ACK after a programmable latency, and on that transition the write or read is performed. P_ACK goes back to P_IDLE when the request is removed.

Top module: `phy_mbox_top`

## Requirements
- R1: After reset the mailbox word reads 0x00000000, so the ACK bit (bit 26) is low.
- R2: A software write stores bits [5:0] as the address, bits [15:8] as write data, bit 24 as WR and bit 25 as RD. Read data (bits [23:16]) and ACK (bit 26) cannot be written, and bits [7:6] and [31:27] always read 0.
- R3: After WR is set, ACK goes high and stays high for as long as WR stays set. ACK returns low after WR is cleared, and only then may the next access start.
- R4: For a read, bits [23:16] hold the addressed PHY byte by the time ACK first reads high. They keep that value until another read completes, and writes leave them unchanged.
- R5: After reset every PHY entry at address a holds 0x80 | a.
- R6: A byte written to an address is returned by a later read of that address, and other addresses are left unchanged.
- R7: A strobe that is set while ACK still reads high is held off. ACK must first read low; the pending access then runs.
- R8: When WR and RD are set together, only a write is performed and bits [23:16] do not change.
- R9: Each ACK wait in an access completes within 1000 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Write enable for the mailbox word |
| host_wdata | input | 32 | Mailbox word written by software |
| host_rdata | output | 32 | Current mailbox word: fields, read data, ACK |

## Verification
A host machine stuck outside H_IDLE shows at the ports as an ACK bit that never falls, or as a later strobe that never gets an ACK. Either appears within one access, as an expired wait. A wrong latch of the address or data at issue shows only later, when a read-back returns the wrong byte or a reset value that should have been overwritten. The read-data field is watched at every cycle, so a capture at the wrong moment shows up as a change without an ACK rise.

// File: rtl/phy_mbox_pkg.sv
package phy_mbox_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 8;
    localparam int ADDR_LSB  = 0;
    localparam int WDATA_LSB = 8;
    localparam int RDATA_LSB = 16;
    localparam int WR_BIT    = 24;
    localparam int RD_BIT    = 25;
    localparam int ACK_BIT   = 26;

    typedef enum logic [1:0] {
        H_IDLE,
        H_REQ,
        H_HOLD,
        H_DRAIN
    } host_state_t;

    typedef enum logic [1:0] {
        P_IDLE,
        P_WAIT,
        P_ACK
    } phy_state_t;
endpackage

// File: rtl/phy_mbox_host.sv
module phy_mbox_host
    import phy_mbox_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] sw_rdata,
    input  logic              phy_ack,
    input  logic [DW-1:0]     phy_rdata,
    output logic              req_wr,
    output logic              req_rd,
    output logic [AW-1:0]     req_addr,
    output logic [DW-1:0]     req_wdata
);
    host_state_t state_q, state_d;

    logic [AW-1:0] fld_addr;
    logic [DW-1:0] fld_wdata;
    logic [DW-1:0] fld_rdata;
    logic          fld_wr;
    logic          fld_rd;
    logic          op_is_wr;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic          strobe_any;
    logic          op_strobe;

    assign strobe_any = fld_wr | fld_rd;
    assign op_strobe  = op_is_wr ? fld_wr : fld_rd;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= H_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_IDLE:  if (strobe_any && !phy_ack) state_d = H_REQ;
            H_REQ:   if (phy_ack)                state_d = H_HOLD;
            H_HOLD:  if (!op_strobe)             state_d = H_DRAIN;
            H_DRAIN: if (!phy_ack)               state_d = H_IDLE;
            default:                             state_d = H_IDLE;
        endcase
    end

    // Software fields, issue latch and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_addr  <= '0;
            fld_wdata <= '0;
            fld_rdata <= '0;
            fld_wr    <= 1'b0;
            fld_rd    <= 1'b0;
            op_is_wr  <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else begin
            if (sw_we) begin
                fld_addr  <= sw_wdata[ADDR_LSB +: AW];
                fld_wdata <= sw_wdata[WDATA_LSB +: DW];
                fld_wr    <= sw_wdata[WR_BIT];
                fld_rd    <= sw_wdata[RD_BIT];
            end
            if (state_q == H_IDLE && state_d == H_REQ) begin
                op_is_wr  <= fld_wr;
                lat_addr  <= fld_addr;
                lat_wdata <= fld_wdata;
            end
            if (state_q == H_REQ && phy_ack && !op_is_wr) begin
                fld_rdata <= phy_rdata;
            end
        end
    end

    // Outputs.
    always_comb begin
        req_wr    = 1'b0;
        req_rd    = 1'b0;
        req_addr  = lat_addr;
        req_wdata = lat_wdata;
        sw_rdata  = '0;
        unique case (state_q)
            H_REQ, H_HOLD: begin
                req_wr = op_is_wr;
                req_rd = !op_is_wr;
            end
            default: begin
                req_wr = 1'b0;
                req_rd = 1'b0;
            end
        endcase
        sw_rdata[ADDR_LSB  +: AW] = fld_addr;
        sw_rdata[WDATA_LSB +: DW] = fld_wdata;
        sw_rdata[RDATA_LSB +: DW] = fld_rdata;
        sw_rdata[WR_BIT]          = fld_wr;
        sw_rdata[RD_BIT]          = fld_rd;
        sw_rdata[ACK_BIT]         = (state_q == H_HOLD) || (state_q == H_DRAIN);
    end
endmodule

// File: rtl/phy_mbox_phy.sv
module phy_mbox_phy
    import phy_mbox_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W,
    parameter int ACK_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_wr,
    input  logic          req_rd,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;
    localparam int CNT_W = $clog2(ACK_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_LAT - 1);
    localparam logic [DW-1:0] RST_TAG = DW'(1) << (DW - 1);

    phy_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]    mem [DEPTH];
    logic             req_any;

    assign req_any = req_wr | req_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= P_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE: if (req_any)            state_d = P_WAIT;
            P_WAIT: if (cnt_q == CNT_LAST)  state_d = P_ACK;
            P_ACK:  if (!req_any)           state_d = P_IDLE;
            default:                        state_d = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rdata <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= RST_TAG | DW'(i);
            end
        end else begin
            if (state_q == P_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == P_WAIT) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == P_WAIT && state_d == P_ACK) begin
                if (req_wr) begin
                    mem[req_addr] <= req_wdata;
                end else begin
                    rdata <= mem[req_addr];
                end
            end
        end
    end

    always_comb begin
        ack = (state_q == P_ACK);
    end
endmodule

// File: rtl/phy_mbox_top.sv
module phy_mbox_top
    import phy_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata
);
    logic              req_wr;
    logic              req_rd;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              phy_ack;
    logic [DATA_W-1:0] phy_rdata;

    phy_mbox_host #(.AW(ADDR_W), .DW(DATA_W)) host_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_we     (host_we),
        .sw_wdata  (host_wdata),
        .sw_rdata  (host_rdata),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .req_wr    (req_wr),
        .req_rd    (req_rd),
        .req_addr  (req_addr),
        .req_wdata (req_wdata)
    );

    phy_mbox_phy #(.AW(ADDR_W), .DW(DATA_W), .ACK_LAT(2)) phy_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_wr    (req_wr),
        .req_rd    (req_rd),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ack       (phy_ack),
        .rdata     (phy_rdata)
    );
endmodule

// File: rtl/phy_mbox_chk.sv
module phy_mbox_chk
    import phy_mbox_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_wr,
    input logic              req_rd,
    input logic              phy_ack,
    input logic [WORD_W-1:0] sw_word
);
    // R3
    ack_rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_ack) |-> $past(req_wr || req_rd));
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_wr || req_rd) && !phy_ack) |=> (req_wr || req_rd));
    // R3
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_ack && (req_wr || req_rd)) |=> phy_ack);
    // R8
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_wr && req_rd));
    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sw_word[ACK_BIT]) |-> $stable(sw_word[RDATA_LSB +: DATA_W]));
    // R7
    req_after_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_wr || req_rd) |-> (!phy_ack && !$past(sw_word[ACK_BIT])));
endmodule

bind phy_mbox_top phy_mbox_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_wr  (req_wr),
    .req_rd  (req_rd),
    .phy_ack (phy_ack),
    .sw_word (host_rdata)
);

// File: tb/phy_mbox_top_tb_top.sv
module phy_mbox_top_tb_top;
    localparam int TIMEOUT = 1000;
    localparam int N_INIT  = 6;
    localparam logic [13:0] INIT_TBL [N_INIT] = '{
        {6'd0,  8'h11}, {6'd1,  8'h22}, {6'd7,  8'h5A},
        {6'd33, 8'hC3}, {6'd62, 8'h00}, {6'd63, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    int          n_checks = 0;
    int          n_fails = 0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    phy_mbox_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] a, input logic [7:0] d, input bit wr, input bit rd);
        mk = {6'd0, rd, wr, 8'd0, d, 2'd0, a};
    endfunction

    task automatic sw_write(input logic [31:0] w);
        @(negedge clk);
        host_we = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_ack(input bit level, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < TIMEOUT; i++) begin
            if (host_rdata[26] == level) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic phy_write(input logic [5:0] a, input logic [7:0] d, output bit ok);
        bit o1, o2, o3;
        wait_ack(1'b0, o1);
        sw_write(mk(a, d, 1'b0, 1'b0));
        sw_write(mk(a, d, 1'b1, 1'b0));
        wait_ack(1'b1, o2);
        sw_write(mk(a, d, 1'b0, 1'b0));
        wait_ack(1'b0, o3);
        ok = o1 && o2 && o3;
    endtask

    task automatic phy_read(input logic [5:0] a, output logic [7:0] d, output bit ok);
        bit o1, o2, o3;
        wait_ack(1'b0, o1);
        sw_write(mk(a, 8'h00, 1'b0, 1'b0));
        sw_write(mk(a, 8'h00, 1'b0, 1'b1));
        wait_ack(1'b1, o2);
        d = host_rdata[23:16];
        sw_write(mk(a, 8'h00, 1'b0, 1'b0));
        wait_ack(1'b0, o3);
        ok = o1 && o2 && o3;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        bit ok;
        bit held;
        logic [7:0] rd;
        logic [7:0] exp8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(host_rdata == 32'h0, "R1", host_rdata, 32'h0);

        // R2 field layout: all bits but the strobes written
        sw_write(32'hFCFF_FFFF);
        @(negedge clk);
        check(host_rdata == 32'h0000_FF3F, "R2", host_rdata, 32'h0000_FF3F);

        // R5 reset contents of untouched entries
        phy_read(6'd20, rd, ok);
        check(ok && rd == 8'h94, "R5", {24'd0, rd}, 32'h94);
        phy_read(6'd63, rd, ok);
        check(ok && rd == 8'hBF, "R5", {24'd0, rd}, 32'hBF);

        // R9 initialisation list: every wait bounded
        for (int i = 0; i < N_INIT; i++) begin
            phy_write(INIT_TBL[i][13:8], INIT_TBL[i][7:0], ok);
            check(ok, "R9", {31'd0, ok}, 32'd1);
        end
        // R6 read back the list
        for (int i = 0; i < N_INIT; i++) begin
            phy_read(INIT_TBL[i][13:8], rd, ok);
            check(ok && rd == INIT_TBL[i][7:0], "R6", {24'd0, rd}, {24'd0, INIT_TBL[i][7:0]});
        end
        // R6 neighbour untouched
        phy_read(6'd2, rd, ok);
        check(ok && rd == 8'h82, "R6", {24'd0, rd}, 32'h82);

        // R3 ack stays high while WR held, falls after release
        sw_write(mk(6'd40, 8'h6E, 1'b0, 1'b0));
        sw_write(mk(6'd40, 8'h6E, 1'b1, 1'b0));
        check(host_rdata[26] == 1'b0, "R3", {31'd0, host_rdata[26]}, 32'd0);
        wait_ack(1'b1, ok);
        check(ok, "R3", {31'd0, ok}, 32'd1);
        held = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!host_rdata[26]) held = 1'b0;
        end
        check(held, "R3", {31'd0, held}, 32'd1);
        sw_write(mk(6'd40, 8'h6E, 1'b0, 1'b0));
        wait_ack(1'b0, ok);
        check(ok, "R3", {31'd0, ok}, 32'd1);

        // R4 read data held across a later write
        phy_read(6'd40, rd, ok);
        check(ok && rd == 8'h6E, "R4", {24'd0, rd}, 32'h6E);
        phy_write(6'd41, 8'h12, ok);
        check(host_rdata[23:16] == 8'h6E, "R4", {24'd0, host_rdata[23:16]}, 32'h6E);

        // R7 read strobe set while ack still high from a write
        sw_write(mk(6'd5, 8'h3C, 1'b0, 1'b0));
        sw_write(mk(6'd5, 8'h3C, 1'b1, 1'b0));
        wait_ack(1'b1, ok);
        sw_write(mk(6'd9, 8'h00, 1'b0, 1'b1));
        wait_ack(1'b0, ok);
        check(ok, "R7", {31'd0, ok}, 32'd1);
        wait_ack(1'b1, ok);
        check(ok && host_rdata[23:16] == 8'h89, "R7", {24'd0, host_rdata[23:16]}, 32'h89);
        sw_write(mk(6'd9, 8'h00, 1'b0, 1'b0));
        wait_ack(1'b0, ok);
        phy_read(6'd5, rd, ok);
        check(ok && rd == 8'h3C, "R7", {24'd0, rd}, 32'h3C);

        // R8 both strobes: write only
        exp8 = host_rdata[23:16];
        sw_write(mk(6'd12, 8'h77, 1'b0, 1'b0));
        sw_write(mk(6'd12, 8'h77, 1'b1, 1'b1));
        wait_ack(1'b1, ok);
        check(ok && host_rdata[23:16] == exp8, "R8", {24'd0, host_rdata[23:16]}, {24'd0, exp8});
        sw_write(mk(6'd12, 8'h77, 1'b0, 1'b0));
        wait_ack(1'b0, ok);
        phy_read(6'd12, rd, ok);
        check(ok && rd == 8'h77, "R8", {24'd0, rd}, 32'h77);

        // R1 reset in mid-use returns word and contents to defaults
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_rdata == 32'h0, "R1", host_rdata, 32'h0);
        phy_read(6'd12, rd, ok);
        check(ok && rd == 8'h8C, "R5", {24'd0, rd}, 32'h8C);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule